// File: doc/BRIEF.md
# Split Main and Pinned Translation Buffer

This block caches virtual-to-physical translations for a 32-bit address space. Two structures hold them. The main array is a two-way set-associative store of 64 entries. The pinned array is a small fully associative store whose entries only leave when software clears them. This keeps chosen regions free of table-walk penalties. Each entry maps a region of 1KB, 4KB, 64KB or 1MB. It also carries the region's 4-bit domain and its access-permission bits.

A lookup presents a virtual address. One cycle later the block answers with a hit, or with a single-cycle miss. A hit returns the physical address, size, domain and permission bits. An external walker resolves misses and writes its results through the fill port. The fill port can steer an entry into a chosen pinned slot. Software can flush the whole main array, or clear pinned slots one at a time.

Top module: `split_tlb`

## Requirements
- R1: While reset is active and after it, both `rsp_hit` and `rsp_miss` are low, and every entry is empty, so any lookup after reset misses.
- R2: A lookup accepted on a clock edge (`lu_valid` high) is answered at the following edge with exactly one of `rsp_hit` or `rsp_miss` high. Without a lookup, both stay low.
- R3: On a miss, `rsp_pa`, `rsp_size`, `rsp_dom` and `rsp_ap` are all zero.
- R4: The size codes are 0 = 1KB, 1 = 4KB, 2 = 64KB and 3 = 1MB. On a hit, the address bits below the size boundary (10, 12, 16 or 20 bits) come from the lookup address and the bits above it come from the entry. Only the bits above the boundary are compared.
- R5: The main array picks its set from virtual address bits [16:12] (32 sets, two ways). A large mapping in the main array therefore hits only for lookups that share those bits with its fill address. Within a set, one round-robin bit per set selects the way a fill writes, and each fill toggles that bit. A third fill to a set evicts the oldest of its two entries.
- R6: A fill with `fill_lock` high is written to pinned slot `fill_slot` and to no main entry. Main-array fills never evict a pinned entry.
- R7: Both arrays are searched on every lookup. When both hit, the pinned entry supplies the response.
- R8: `inv_all` empties every main entry and leaves the pinned slots intact.
- R9: `inv_slot_valid` empties only pinned slot `inv_slot`.
- R10: A hit returns the domain, permission bits and size code written by the fill, unchanged.
- R11: A lookup in the same cycle as a fill or an invalidation sees the contents from before that update.
- R12: When `inv_all` and a main fill arrive together, the fill is dropped. When a pinned fill and a clear of the same slot arrive together, the slot ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lu_valid | input | 1 | Lookup request |
| lu_va | input | 32 | Lookup virtual address |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_miss | output | 1 | Lookup found nothing (one-cycle pulse) |
| rsp_pa | output | 32 | Translated physical address |
| rsp_size | output | 2 | Size code of the hit entry |
| rsp_dom | output | 4 | Domain of the hit entry |
| rsp_ap | output | 2 | Access-permission bits of the hit entry |
| fill_valid | input | 1 | Write a walk result |
| fill_vpn | input | 22 | Virtual address bits [31:10] of the fill |
| fill_ppn | input | 22 | Physical address bits [31:10] of the fill |
| fill_size | input | 2 | Size code of the fill |
| fill_dom | input | 4 | Domain of the fill |
| fill_ap | input | 2 | Access-permission bits of the fill |
| fill_lock | input | 1 | Steer the fill into a pinned slot |
| fill_slot | input | 3 | Pinned slot index |
| inv_all | input | 1 | Empty the whole main array |
| inv_slot_valid | input | 1 | Empty one pinned slot |
| inv_slot | input | 3 | Pinned slot to empty |

## Verification
A corrupted round-robin bit shows up as the wrong survivor after a third fill to a set. It is seen on the first lookup of the older entry, one cycle after that lookup. A stale valid bit after a flush or a slot clear turns an expected miss into a hit on the next lookup of that region. A wrong compare mask either misses within a large page or hits on the wrong 1KB page. A broken priority returns the main entry's address and domain where the pinned entry's were due. Each of these faults appears on the response registers one cycle after the lookup that exposes it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned MIN_OFF  = 10;
  localparam int unsigned OFF_4K   = 12;
  localparam int unsigned OFF_64K  = 16;
  localparam int unsigned OFF_1M   = 20;
  localparam int unsigned TAG_W    = ADDR_W - MIN_OFF;
  localparam int unsigned DOM_W    = 4;
  localparam int unsigned AP_W     = 2;

  typedef enum logic [1:0] {
    PG_1K  = 2'd0,
    PG_4K  = 2'd1,
    PG_64K = 2'd2,
    PG_1M  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] vtag;
    logic [TAG_W-1:0] ptag;
    pg_size_e         size;
    logic [DOM_W-1:0] dom;
    logic [AP_W-1:0]  ap;
  } tlb_entry_t;

  typedef struct packed {
    logic             hit;
    logic [TAG_W-1:0] ptag;
    pg_size_e         size;
    logic [DOM_W-1:0] dom;
    logic [AP_W-1:0]  ap;
  } tlb_res_t;

  // Tag bits that take part in the compare for a given mapping size.
  function automatic logic [TAG_W-1:0] tag_keep_mask(input pg_size_e s);
    logic [TAG_W-1:0] ones;
    ones = '1;
    case (s)
      PG_1K:   return ones;
      PG_4K:   return ones << (OFF_4K - MIN_OFF);
      PG_64K:  return ones << (OFF_64K - MIN_OFF);
      PG_1M:   return ones << (OFF_1M - MIN_OFF);
      default: return ones;
    endcase
  endfunction
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
(
  input  tlb_entry_t       ent,
  input  logic [TAG_W-1:0] va_tag,
  output logic             hit,
  output logic [TAG_W-1:0] pa_tag
);
  logic [TAG_W-1:0] keep;

  always_comb begin
    keep   = tag_keep_mask(ent.size);
    hit    = ent.valid && ((ent.vtag & keep) == (va_tag & keep));
    pa_tag = (ent.ptag & keep) | (va_tag & ~keep);
  end
endmodule

// File: rtl/tlb_main_array.sv
module tlb_main_array
  import tlb_pkg::*;
#(
  parameter int unsigned SETS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lu_tag,
  input  logic             fill_en,
  input  tlb_entry_t       fill_ent,
  input  logic             flush,
  output tlb_res_t         res
);
  localparam int unsigned WAYS   = 2;
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned IDX_LO = OFF_4K - MIN_OFF;

  tlb_entry_t       ent_q [SETS][WAYS];
  tlb_entry_t       ent_d [SETS][WAYS];
  logic [SETS-1:0]  rr_q, rr_d;
  logic             upd_en;
  logic [IDX_W-1:0] lu_set, fill_set;

  assign lu_set   = lu_tag[IDX_LO +: IDX_W];
  assign fill_set = fill_ent.vtag[IDX_LO +: IDX_W];
  assign upd_en   = flush | fill_en;

  // Next state: a flush wins over a fill in the same cycle.
  always_comb begin
    ent_d = ent_q;
    rr_d  = rr_q;
    if (flush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_d[s][w].valid = 1'b0;
    end else if (fill_en) begin
      ent_d[fill_set][rr_q[fill_set]] = fill_ent;
      rr_d[fill_set]                  = ~rr_q[fill_set];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_q[s][w] <= '0;
      rr_q <= '0;
    end else if (upd_en) begin
      ent_q <= ent_d;
      rr_q  <= rr_d;
    end
  end

  tlb_entry_t       way_ent  [WAYS];
  logic [WAYS-1:0]  way_hit;
  logic [TAG_W-1:0] way_ptag [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_ent[w] = ent_q[lu_set][w];
    tlb_entry_match u_match (
      .ent    (way_ent[w]),
      .va_tag (lu_tag),
      .hit    (way_hit[w]),
      .pa_tag (way_ptag[w])
    );
  end

  always_comb begin
    res = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        res.hit  = 1'b1;
        res.ptag = way_ptag[w];
        res.size = way_ent[w].size;
        res.dom  = way_ent[w].dom;
        res.ap   = way_ent[w].ap;
      end
    end
  end
endmodule

// File: rtl/tlb_lock_array.sv
module tlb_lock_array
  import tlb_pkg::*;
#(
  parameter int unsigned LOCK_N = 8,
  localparam int unsigned SLOT_W = $clog2(LOCK_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lu_tag,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_slot,
  input  tlb_entry_t        fill_ent,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  output tlb_res_t          res
);
  tlb_entry_t ent_q [LOCK_N];
  tlb_entry_t ent_d [LOCK_N];
  logic       upd_en;

  assign upd_en = fill_en | clr_en;

  // Next state: a slot clear is applied after a fill, so it wins on the same slot.
  always_comb begin
    ent_d = ent_q;
    if (fill_en) ent_d[fill_slot] = fill_ent;
    if (clr_en)  ent_d[clr_slot].valid = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOCK_N; i++) ent_q[i] <= '0;
    end else if (upd_en) begin
      ent_q <= ent_d;
    end
  end

  logic [LOCK_N-1:0] slot_hit;
  logic [TAG_W-1:0]  slot_ptag [LOCK_N];

  for (genvar i = 0; i < LOCK_N; i++) begin : g_slot
    tlb_entry_match u_match (
      .ent    (ent_q[i]),
      .va_tag (lu_tag),
      .hit    (slot_hit[i]),
      .pa_tag (slot_ptag[i])
    );
  end

  always_comb begin
    res = '0;
    for (int i = LOCK_N - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        res.hit  = 1'b1;
        res.ptag = slot_ptag[i];
        res.size = ent_q[i].size;
        res.dom  = ent_q[i].dom;
        res.ap   = ent_q[i].ap;
      end
    end
  end
endmodule

// File: rtl/split_tlb.sv
module split_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned SETS   = 32,
  parameter int unsigned LOCK_N = 8,
  localparam int unsigned SLOT_W = $clog2(LOCK_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lu_valid,
  input  logic [ADDR_W-1:0]   lu_va,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [ADDR_W-1:0]   rsp_pa,
  output logic [1:0]          rsp_size,
  output logic [DOM_W-1:0]    rsp_dom,
  output logic [AP_W-1:0]     rsp_ap,
  input  logic                fill_valid,
  input  logic [TAG_W-1:0]    fill_vpn,
  input  logic [TAG_W-1:0]    fill_ppn,
  input  logic [1:0]          fill_size,
  input  logic [DOM_W-1:0]    fill_dom,
  input  logic [AP_W-1:0]     fill_ap,
  input  logic                fill_lock,
  input  logic [SLOT_W-1:0]   fill_slot,
  input  logic                inv_all,
  input  logic                inv_slot_valid,
  input  logic [SLOT_W-1:0]   inv_slot
);
  logic       rst_sync_n;
  tlb_entry_t fill_ent;
  tlb_res_t   main_res, lock_res;
  logic [TAG_W-1:0] lu_tag;

  tlb_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign lu_tag = lu_va[ADDR_W-1:MIN_OFF];

  always_comb begin
    fill_ent.valid = 1'b1;
    fill_ent.vtag  = fill_vpn;
    fill_ent.ptag  = fill_ppn;
    fill_ent.size  = pg_size_e'(fill_size);
    fill_ent.dom   = fill_dom;
    fill_ent.ap    = fill_ap;
  end

  tlb_main_array #(.SETS(SETS)) u_main (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lu_tag   (lu_tag),
    .fill_en  (fill_valid & ~fill_lock),
    .fill_ent (fill_ent),
    .flush    (inv_all),
    .res      (main_res)
  );

  tlb_lock_array #(.LOCK_N(LOCK_N)) u_lock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lu_tag    (lu_tag),
    .fill_en   (fill_valid & fill_lock),
    .fill_slot (fill_slot),
    .fill_ent  (fill_ent),
    .clr_en    (inv_slot_valid),
    .clr_slot  (inv_slot),
    .res       (lock_res)
  );

  // Response next state: pinned hit over main hit, otherwise miss.
  logic              hit_d, miss_d;
  logic [ADDR_W-1:0] pa_d;
  logic [1:0]        size_d;
  logic [DOM_W-1:0]  dom_d;
  logic [AP_W-1:0]   ap_d;
  tlb_res_t          sel;

  always_comb begin
    sel    = lock_res.hit ? lock_res : main_res;
    hit_d  = 1'b0;
    miss_d = 1'b0;
    pa_d   = '0;
    size_d = '0;
    dom_d  = '0;
    ap_d   = '0;
    if (lu_valid) begin
      if (sel.hit) begin
        hit_d  = 1'b1;
        pa_d   = {sel.ptag, lu_va[MIN_OFF-1:0]};
        size_d = sel.size;
        dom_d  = sel.dom;
        ap_d   = sel.ap;
      end else begin
        miss_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_hit  <= 1'b0;
      rsp_miss <= 1'b0;
      rsp_pa   <= '0;
      rsp_size <= '0;
      rsp_dom  <= '0;
      rsp_ap   <= '0;
    end else begin
      rsp_hit  <= hit_d;
      rsp_miss <= miss_d;
      rsp_pa   <= pa_d;
      rsp_size <= size_d;
      rsp_dom  <= dom_d;
      rsp_ap   <= ap_d;
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lu_valid,
  input logic [ADDR_W-1:0] lu_va,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic [1:0]        rsp_size,
  input logic [DOM_W-1:0]  rsp_dom,
  input logic [AP_W-1:0]   rsp_ap
);
  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |=> (rsp_hit ^ rsp_miss));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_valid |=> (!rsp_hit && !rsp_miss));

  p_miss_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0 && rsp_size == '0 && rsp_dom == '0 && rsp_ap == '0));

  p_low_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_pa[MIN_OFF-1:0] == $past(lu_va[MIN_OFF-1:0])));

  p_section_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && rsp_size == PG_1M) |-> (rsp_pa[OFF_1M-1:0] == $past(lu_va[OFF_1M-1:0])));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!rsp_hit && !rsp_miss));
endmodule

bind split_tlb tlb_checker i_tlb_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .lu_valid (lu_valid),
  .lu_va    (lu_va),
  .rsp_hit  (rsp_hit),
  .rsp_miss (rsp_miss),
  .rsp_pa   (rsp_pa),
  .rsp_size (rsp_size),
  .rsp_dom  (rsp_dom),
  .rsp_ap   (rsp_ap)
);

// File: tb/test_split_tlb.sv
module test_split_tlb;
  logic        clk;
  logic        rst_n;
  logic        lu_valid;
  logic [31:0] lu_va;
  logic        rsp_hit, rsp_miss;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic [3:0]  rsp_dom;
  logic [1:0]  rsp_ap;
  logic        fill_valid;
  logic [21:0] fill_vpn, fill_ppn;
  logic [1:0]  fill_size;
  logic [3:0]  fill_dom;
  logic [1:0]  fill_ap;
  logic        fill_lock;
  logic [2:0]  fill_slot;
  logic        inv_all;
  logic        inv_slot_valid;
  logic [2:0]  inv_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  split_tlb i_split_tlb (
    .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_va(lu_va),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
    .rsp_dom(rsp_dom), .rsp_ap(rsp_ap), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_dom(fill_dom), .fill_ap(fill_ap),
    .fill_lock(fill_lock), .fill_slot(fill_slot), .inv_all(inv_all),
    .inv_slot_valid(inv_slot_valid), .inv_slot(inv_slot)
  );

  task automatic check_rsp(input string rq, input logic eh, input logic [31:0] epa,
                           input logic [1:0] esz, input logic [3:0] ed, input logic [1:0] eap);
    logic [31:0] xpa; logic [1:0] xsz; logic [3:0] xd; logic [1:0] xap;
    xpa = eh ? epa : 32'h0; xsz = eh ? esz : 2'd0; xd = eh ? ed : 4'd0; xap = eh ? eap : 2'd0;
    checks++;
    if (rsp_hit !== eh || rsp_miss !== !eh || rsp_pa !== xpa || rsp_size !== xsz ||
        rsp_dom !== xd || rsp_ap !== xap) begin
      errors++;
      $display("FAIL %s: got hit=%b miss=%b pa=%h size=%0d dom=%0d ap=%0d, expected hit=%b miss=%b pa=%h size=%0d dom=%0d ap=%0d",
               rq, rsp_hit, rsp_miss, rsp_pa, rsp_size, rsp_dom, rsp_ap,
               eh, !eh, xpa, xsz, xd, xap);
    end
  endtask

  task automatic check_quiet(input string rq);
    checks++;
    if (rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
      errors++;
      $display("FAIL %s: got hit=%b miss=%b, expected hit=0 miss=0", rq, rsp_hit, rsp_miss);
    end
  endtask

  task automatic do_lookup(input string rq, input logic [31:0] va, input logic eh,
                           input logic [31:0] epa, input logic [1:0] esz,
                           input logic [3:0] ed, input logic [1:0] eap);
    @(negedge clk); lu_valid = 1'b1; lu_va = va;
    @(negedge clk); lu_valid = 1'b0;
    check_rsp(rq, eh, epa, esz, ed, eap);
  endtask

  task automatic set_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                          input logic [3:0] d, input logic [1:0] ap, input logic lk,
                          input logic [2:0] slot);
    fill_valid = 1'b1; fill_vpn = va[31:10]; fill_ppn = pa[31:10]; fill_size = sz;
    fill_dom = d; fill_ap = ap; fill_lock = lk; fill_slot = slot;
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                         input logic [3:0] d, input logic [1:0] ap, input logic lk,
                         input logic [2:0] slot);
    @(negedge clk); set_fill(va, pa, sz, d, ap, lk, slot);
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R1 after reset");
    do_lookup("R1 empty lookup", 32'h0004_3ABC, 0, 0, 0, 0, 0);
    do_lookup("R1 empty lookup high", 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_quiet("R2 idle after lookup");
  endtask

  task automatic t_sizes();
    do_fill(32'h0004_3000, 32'h8765_4000, 2'd1, 4'd5, 2'd3, 0, 0);
    do_fill(32'h0000_1400, 32'h2222_2C00, 2'd0, 4'd1, 2'd2, 0, 0);
    do_fill(32'h1234_5000, 32'hABCD_0000, 2'd2, 4'd9, 2'd0, 0, 0);
    do_fill(32'h3010_7000, 32'h5550_0000, 2'd3, 4'd15, 2'd1, 0, 0);
    do_lookup("R4 R10 4KB hit", 32'h0004_3ABC, 1, 32'h8765_4ABC, 2'd1, 4'd5, 2'd3);
    do_lookup("R4 1KB hit", 32'h0000_1410, 1, 32'h2222_2C10, 2'd0, 4'd1, 2'd2);
    do_lookup("R4 1KB neighbour miss", 32'h0000_1010, 0, 0, 0, 0, 0);
    do_lookup("R4 R10 64KB hit", 32'h1234_5ABC, 1, 32'hABCD_5ABC, 2'd2, 4'd9, 2'd0);
    do_lookup("R5 64KB other set miss", 32'h1234_0ABC, 0, 0, 0, 0, 0);
    do_lookup("R4 R10 1MB hit", 32'h3018_7123, 1, 32'h5558_7123, 2'd3, 4'd15, 2'd1);
  endtask

  task automatic t_round_robin();
    do_fill(32'h0100_9000, 32'hA100_0000, 2'd1, 4'd0, 2'd0, 0, 0);
    do_fill(32'h0200_9000, 32'hA200_0000, 2'd1, 4'd0, 2'd0, 0, 0);
    do_lookup("R5 way A", 32'h0100_9010, 1, 32'hA100_0010, 2'd1, 4'd0, 2'd0);
    do_lookup("R5 way B", 32'h0200_9010, 1, 32'hA200_0010, 2'd1, 4'd0, 2'd0);
    do_fill(32'h0300_9000, 32'hA300_0000, 2'd1, 4'd0, 2'd0, 0, 0);
    do_lookup("R5 A evicted", 32'h0100_9010, 0, 0, 0, 0, 0);
    do_lookup("R5 B kept", 32'h0200_9010, 1, 32'hA200_0010, 2'd1, 4'd0, 2'd0);
    do_fill(32'h0400_9000, 32'hA400_0000, 2'd1, 4'd0, 2'd0, 0, 0);
    do_lookup("R5 B evicted", 32'h0200_9010, 0, 0, 0, 0, 0);
    do_lookup("R5 C kept", 32'h0300_9010, 1, 32'hA300_0010, 2'd1, 4'd0, 2'd0);
    do_lookup("R5 D kept", 32'h0400_9010, 1, 32'hA400_0010, 2'd1, 4'd0, 2'd0);
  endtask

  task automatic t_lock();
    do_fill(32'h4000_0000, 32'h9000_0000, 2'd3, 4'd7, 2'd1, 1, 3'd2);
    do_lookup("R6 pinned section any set", 32'h400A_B123, 1, 32'h900A_B123, 2'd3, 4'd7, 2'd1);
    do_fill(32'h4000_0000, 32'h7000_0000, 2'd1, 4'd2, 2'd0, 0, 0);
    do_lookup("R7 pinned wins", 32'h4000_0456, 1, 32'h9000_0456, 2'd3, 4'd7, 2'd1);
    do_fill(32'h5000_0000, 32'h7100_0000, 2'd1, 4'd3, 2'd2, 0, 0);
    do_fill(32'h6000_0000, 32'h7200_0000, 2'd1, 4'd3, 2'd2, 0, 0);
    do_lookup("R6 main fill hit", 32'h5000_0010, 1, 32'h7100_0010, 2'd1, 4'd3, 2'd2);
    do_lookup("R6 main fill hit 2", 32'h6000_0020, 1, 32'h7200_0020, 2'd1, 4'd3, 2'd2);
    do_lookup("R6 pinned survives", 32'h4000_0456, 1, 32'h9000_0456, 2'd3, 4'd7, 2'd1);
  endtask

  task automatic t_inv_all();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    do_lookup("R8 main flushed", 32'h0004_3ABC, 0, 0, 0, 0, 0);
    do_lookup("R8 main flushed 2", 32'h6000_0020, 0, 0, 0, 0, 0);
    do_lookup("R8 pinned kept", 32'h400A_B123, 1, 32'h900A_B123, 2'd3, 4'd7, 2'd1);
  endtask

  task automatic t_inv_slot();
    do_fill(32'h6000_0000, 32'hA000_0000, 2'd3, 4'd4, 2'd3, 1, 3'd4);
    @(negedge clk); inv_slot_valid = 1'b1; inv_slot = 3'd2;
    @(negedge clk); inv_slot_valid = 1'b0;
    do_lookup("R9 slot cleared", 32'h400A_B123, 0, 0, 0, 0, 0);
    do_lookup("R9 other slot kept", 32'h6001_2345, 1, 32'hA001_2345, 2'd3, 4'd4, 2'd3);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lu_valid = 1'b1; lu_va = 32'h0A00_2044;
    set_fill(32'h0A00_2000, 32'hB000_2000, 2'd1, 4'd6, 2'd1, 0, 0);
    @(negedge clk); lu_valid = 1'b0; fill_valid = 1'b0;
    check_rsp("R11 lookup with fill sees old", 0, 0, 0, 0, 0);
    do_lookup("R11 fill visible next", 32'h0A00_2044, 1, 32'hB000_2044, 2'd1, 4'd6, 2'd1);
    @(negedge clk);
    lu_valid = 1'b1; lu_va = 32'h0A00_2044; inv_all = 1'b1;
    @(negedge clk); lu_valid = 1'b0; inv_all = 1'b0;
    check_rsp("R11 lookup with flush sees old", 1, 32'hB000_2044, 2'd1, 4'd6, 2'd1);
    do_lookup("R11 flush visible next", 32'h0A00_2044, 0, 0, 0, 0, 0);
  endtask

  task automatic t_conflict();
    @(negedge clk);
    inv_all = 1'b1;
    set_fill(32'h0B00_3000, 32'hC000_3000, 2'd1, 4'd1, 2'd1, 0, 0);
    @(negedge clk); inv_all = 1'b0; fill_valid = 1'b0;
    do_lookup("R12 fill dropped by flush", 32'h0B00_3000, 0, 0, 0, 0, 0);
    @(negedge clk);
    inv_slot_valid = 1'b1; inv_slot = 3'd6;
    set_fill(32'h0C00_0000, 32'hD000_0000, 2'd3, 4'd2, 2'd2, 1, 3'd6);
    @(negedge clk); inv_slot_valid = 1'b0; fill_valid = 1'b0;
    do_lookup("R12 slot clear wins", 32'h0C00_0000, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lu_valid = 1'b0; lu_va = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_size = '0;
    fill_dom = '0; fill_ap = '0; fill_lock = 1'b0; fill_slot = '0;
    inv_all = 1'b0; inv_slot_valid = 1'b0; inv_slot = '0;
    t_reset();
    t_sizes();
    t_round_robin();
    t_lock();
    t_inv_all();
    t_inv_slot();
    t_same_cycle();
    t_conflict();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule